// File: doc/BRIEF.md
# Packet Header Length Validator

This block checks a stream of scatter-gather segment descriptors before a send engine uses them. Each descriptor gives a byte address and a byte length. A packet opens with a header segment. The first 32-bit word of that header is a control word, and its low bits give the number of words in the packet. That count leaves out the control word itself. The validator checks the header's size and alignment, then reads payload segments until their word total reaches the declared count. It also counts how many memory pages the payload touches.

For each packet that passes, the block gives a one-cycle report: the segment count (header included), the payload page count, a coalesce hint, a batch-end flag and a sequence number from a per-queue counter. A packet that fails gives a one-cycle reject with an error code instead. The block then drops every segment up to and including the one that closes the batch. The block never stalls its input. Data movement and memory pinning are handled elsewhere.

Top module: `hdr_len_validator`

## Requirements
- R1: A header whose length is below 64 bytes or above 4096 bytes is rejected with code 1 (size). Size is checked before alignment.
- R2: A header whose length or address is not a multiple of 4 (and whose size is legal) is rejected with code 2 (alignment).
- R3: The declared count is the control word's bits [10:0]. The starting count is header words minus one. A declared count below the starting count, or above the starting count plus 1024, is rejected with code 3 (count).
- R4: Payload segments are taken while the running count is below the declared count. A payload segment of length 0 or more than 4096 bytes is rejected with code 1. One whose length or address is not a multiple of 4 is rejected with code 2.
- R5: Once the running count reaches or passes the declared count, the two must be equal or the packet is rejected with code 3. A packet whose batch ends (segLast) before its count is reached is also rejected with code 3.
- R6: An accepted packet reports its segment count, header included. It also reports its page count: each payload segment adds 1, plus 1 more if its first and last bytes lie in different 4096-byte pages. A header-only packet reports 1 segment and 0 pages.
- R7: pktCoalesce is set on an accepted packet whose page count is 4 or more.
- R8: Accepted packets carry consecutive sequence numbers starting at 0 after reset. A reject does not advance the sequence. A header whose declared count equals its starting count is accepted on its own.
- R9: After a reject, all following segments up to and including the next one with segLast give no output.
- R10: pktBatchEnd is set on an accepted packet that is the 8th accepted in its batch, or whose last segment carries segLast. A batch starts after reset, after any segment with segLast, and after a batch-ending acceptance.
- R11: After reset no report is pending and segReady is high. Every report is a single-cycle pulse in the cycle after the handshake of the deciding segment. pktValid and rejValid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segValid | input | 1 | Segment descriptor present |
| segReady | output | 1 | Descriptor accepted (always high) |
| segAddr | input | 32 | Segment byte address |
| segLen | input | 13 | Segment byte length |
| segCtrl | input | 32 | First word of a header segment (ignored for payload) |
| segLast | input | 1 | Segment closes the batch |
| pktValid | output | 1 | Accepted-packet report pulse |
| pktSegs | output | 12 | Segments in the packet, header included |
| pktPages | output | 12 | Pages touched by the payload |
| pktCoalesce | output | 1 | Page count reached the fragment limit |
| pktBatchEnd | output | 1 | Packet closes its batch |
| pktSeq | output | 16 | Packet sequence number |
| rejValid | output | 1 | Reject pulse |
| rejCode | output | 2 | 1 size, 2 alignment, 3 count |

## Verification
Two events can land on the same segment, and the bench provokes both. First, a packet can be accepted on the segment that also carries segLast, while it is also the 8th of its batch; acceptance, the batch-end flag and the batch-counter restart then all come from one handshake. Second, a reject can come on the segment that carries segLast; in that case no discard phase follows, and the very next header must be judged normally. A behavioural model holds the running count, page tally, sequence and batch position in plain integers. It predicts both outcomes cycle by cycle, and the bench compares them with the ports on every clock.

// File: rtl/hlv_pkg.sv
package hlv_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_SIZE  = 2'd1,
    ERR_ALIGN = 2'd2,
    ERR_COUNT = 2'd3
  } errCode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic     loadHdr;
    logic     addPay;
    logic     accept;
    logic     reject;
    errCode_e code;
    logic     batchEnd;
  } strobe_t;

endpackage

// File: rtl/hlv_datapath.sv
module hlv_datapath
  import hlv_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int PAGE_BYTES    = 4096,
  parameter int MIN_HDR_BYTES = 64,
  parameter int CNT_W         = 11,
  parameter int SEQ_W         = 16,
  parameter int FRAG_LIMIT    = 4,
  localparam int PG_SH        = $clog2(PAGE_BYTES),
  localparam int LEN_W        = PG_SH + 1,
  localparam int PAGE_WORDS   = PAGE_BYTES / 4,
  localparam int RUN_W        = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] segAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic [31:0]       segCtrl,
  input  strobe_t           strb,
  output errCode_e          hdrCode,
  output logic              hdrCountBad,
  output logic              hdrComplete,
  output errCode_e          payCode,
  output logic              payReach,
  output logic              payExact,
  output logic              pktValid,
  output logic [RUN_W-1:0]  pktSegs,
  output logic [RUN_W-1:0]  pktPages,
  output logic              pktCoalesce,
  output logic              pktBatchEnd,
  output logic [SEQ_W-1:0]  pktSeq,
  output logic              rejValid,
  output errCode_e          rejCode
);

  logic [RUN_W-1:0]  runCnt, declCnt, segCnt, pageCnt;
  logic [SEQ_W-1:0]  seqCnt;
  logic [RUN_W-1:0]  segWords, startCnt, declIn, nextRun, addPages;
  logic [RUN_W-1:0]  finalSegs, finalPages;
  logic [ADDR_W-1:0] lastByte;
  logic              lenTooBig, misaligned, crossPage;

  assign segWords   = RUN_W'(segLen[LEN_W-1:2]);
  assign startCnt   = segWords - RUN_W'(1);
  assign declIn     = RUN_W'(segCtrl[CNT_W-1:0]);
  assign lenTooBig  = segLen > LEN_W'(PAGE_BYTES);
  assign misaligned = (|segLen[1:0]) || (|segAddr[1:0]);

  always_comb begin
    if (segLen < LEN_W'(MIN_HDR_BYTES) || lenTooBig) hdrCode = ERR_SIZE;
    else if (misaligned)                              hdrCode = ERR_ALIGN;
    else                                              hdrCode = ERR_NONE;
    if (segLen == '0 || lenTooBig) payCode = ERR_SIZE;
    else if (misaligned)           payCode = ERR_ALIGN;
    else                           payCode = ERR_NONE;
  end

  assign hdrCountBad = (declIn < startCnt) || (declIn > startCnt + RUN_W'(PAGE_WORDS));
  assign hdrComplete = (declIn == startCnt);

  assign nextRun  = runCnt + segWords;
  assign payReach = nextRun >= declCnt;
  assign payExact = nextRun == declCnt;

  assign lastByte  = segAddr + ADDR_W'(segLen) - ADDR_W'(1);
  assign crossPage = segAddr[ADDR_W-1:PG_SH] != lastByte[ADDR_W-1:PG_SH];
  assign addPages  = crossPage ? RUN_W'(2) : RUN_W'(1);

  assign finalSegs  = strb.addPay ? segCnt + RUN_W'(1) : RUN_W'(1);
  assign finalPages = strb.addPay ? pageCnt + addPages : '0;

  // packet accumulation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt  <= '0;
      declCnt <= '0;
      segCnt  <= '0;
      pageCnt <= '0;
    end else if (strb.loadHdr) begin
      runCnt  <= startCnt;
      declCnt <= declIn;
      segCnt  <= RUN_W'(1);
      pageCnt <= '0;
    end else if (strb.addPay) begin
      runCnt  <= nextRun;
      segCnt  <= segCnt + RUN_W'(1);
      pageCnt <= pageCnt + addPages;
    end
  end

  // report registers and sequence counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCnt      <= '0;
      pktValid    <= 1'b0;
      pktSegs     <= '0;
      pktPages    <= '0;
      pktCoalesce <= 1'b0;
      pktBatchEnd <= 1'b0;
      pktSeq      <= '0;
      rejValid    <= 1'b0;
      rejCode     <= ERR_NONE;
    end else begin
      pktValid <= strb.accept;
      rejValid <= strb.reject;
      if (strb.reject) rejCode <= strb.code;
      if (strb.accept) begin
        pktSegs     <= finalSegs;
        pktPages    <= finalPages;
        pktCoalesce <= finalPages >= RUN_W'(FRAG_LIMIT);
        pktBatchEnd <= strb.batchEnd;
        pktSeq      <= seqCnt;
        seqCnt      <= seqCnt + SEQ_W'(1);
      end
    end
  end

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> seqCnt == pktSeq + SEQ_W'(1));

  p_reject_holds_seq_r8: assert property (@(posedge clk) disable iff (!rstN)
    rejValid |-> $stable(seqCnt));

  p_page_bounds_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktPages >= pktSegs - RUN_W'(1)) &&
                 (pktPages <= (pktSegs - RUN_W'(1)) * RUN_W'(2)));

  p_single_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && rejValid));

endmodule

// File: rtl/hlv_ctrl.sv
module hlv_ctrl
  import hlv_pkg::*;
#(
  parameter int MAX_PKTS = 8,
  localparam int BATCH_W = $clog2(MAX_PKTS + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     segValid,
  input  logic     segLast,
  input  errCode_e hdrCode,
  input  logic     hdrCountBad,
  input  logic     hdrComplete,
  input  errCode_e payCode,
  input  logic     payReach,
  input  logic     payExact,
  output strobe_t  strb
);

  typedef enum logic [1:0] {ST_HDR, ST_PAY, ST_DROP} state_e;

  state_e             state, nextState;
  logic [BATCH_W-1:0] batchCnt, nextBatch;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextBatch = batchCnt;
    if (segValid) begin
      unique case (state)
        ST_HDR: begin
          if (hdrCode != ERR_NONE) begin
            strb.reject = 1'b1;
            strb.code   = hdrCode;
          end else if (hdrCountBad || (!hdrComplete && segLast)) begin
            strb.reject = 1'b1;
            strb.code   = ERR_COUNT;
          end else if (hdrComplete) begin
            strb.accept = 1'b1;
          end else begin
            strb.loadHdr = 1'b1;
            nextState    = ST_PAY;
          end
        end
        ST_PAY: begin
          if (payCode != ERR_NONE) begin
            strb.reject = 1'b1;
            strb.code   = payCode;
          end else begin
            strb.addPay = 1'b1;
            if (payReach && payExact) begin
              strb.accept = 1'b1;
            end else if (payReach || segLast) begin
              strb.reject = 1'b1;
              strb.code   = ERR_COUNT;
            end
          end
        end
        default: if (segLast) nextState = ST_HDR;
      endcase
      if (strb.reject) nextState = segLast ? ST_HDR : ST_DROP;
      if (strb.accept) begin
        nextState     = ST_HDR;
        strb.batchEnd = segLast || (batchCnt == BATCH_W'(MAX_PKTS - 1));
        nextBatch     = strb.batchEnd ? '0 : batchCnt + BATCH_W'(1);
      end else if (segLast) begin
        nextBatch = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_HDR;
      batchCnt <= '0;
    end else begin
      state    <= nextState;
      batchCnt <= nextBatch;
    end
  end

  p_drop_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP) |-> !(strb.accept || strb.reject));

  p_batch_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    batchCnt < BATCH_W'(MAX_PKTS));

endmodule

// File: rtl/hdr_len_validator.sv
module hdr_len_validator
  import hlv_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int PAGE_BYTES    = 4096,
  parameter int MIN_HDR_BYTES = 64,
  parameter int CNT_W         = 11,
  parameter int SEQ_W         = 16,
  parameter int FRAG_LIMIT    = 4,
  parameter int MAX_PKTS      = 8,
  localparam int LEN_W        = $clog2(PAGE_BYTES) + 1,
  localparam int RUN_W        = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segValid,
  output logic              segReady,
  input  logic [ADDR_W-1:0] segAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic [31:0]       segCtrl,
  input  logic              segLast,
  output logic              pktValid,
  output logic [RUN_W-1:0]  pktSegs,
  output logic [RUN_W-1:0]  pktPages,
  output logic              pktCoalesce,
  output logic              pktBatchEnd,
  output logic [SEQ_W-1:0]  pktSeq,
  output logic              rejValid,
  output logic [1:0]        rejCode
);

  strobe_t  strb;
  errCode_e hdrCode, payCode, rejCodeE;
  logic     hdrCountBad, hdrComplete, payReach, payExact;

  assign segReady = 1'b1;
  assign rejCode  = rejCodeE;

  hlv_ctrl #(.MAX_PKTS(MAX_PKTS)) uCtrl (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segLast(segLast),
    .hdrCode(hdrCode), .hdrCountBad(hdrCountBad), .hdrComplete(hdrComplete),
    .payCode(payCode), .payReach(payReach), .payExact(payExact), .strb(strb)
  );

  hlv_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .MIN_HDR_BYTES(MIN_HDR_BYTES),
    .CNT_W(CNT_W), .SEQ_W(SEQ_W), .FRAG_LIMIT(FRAG_LIMIT)
  ) uData (
    .clk(clk), .rstN(rstN), .segAddr(segAddr), .segLen(segLen), .segCtrl(segCtrl),
    .strb(strb), .hdrCode(hdrCode), .hdrCountBad(hdrCountBad),
    .hdrComplete(hdrComplete), .payCode(payCode), .payReach(payReach),
    .payExact(payExact), .pktValid(pktValid), .pktSegs(pktSegs),
    .pktPages(pktPages), .pktCoalesce(pktCoalesce), .pktBatchEnd(pktBatchEnd),
    .pktSeq(pktSeq), .rejValid(rejValid), .rejCode(rejCodeE)
  );

endmodule

// File: tb/sim_hdr_len_validator.sv
`timescale 1ns/1ps
module sim_hdr_len_validator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segValid = 1'b0;
  logic        segReady;
  logic [31:0] segAddr = '0;
  logic [12:0] segLen = '0;
  logic [31:0] segCtrl = '0;
  logic        segLast = 1'b0;
  logic        pktValid, pktCoalesce, pktBatchEnd, rejValid;
  logic [11:0] pktSegs, pktPages;
  logic [15:0] pktSeq;
  logic [1:0]  rejCode;

  always #4 clk = ~clk;

  hdr_len_validator u0 (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segCtrl(segCtrl), .segLast(segLast),
    .pktValid(pktValid), .pktSegs(pktSegs), .pktPages(pktPages),
    .pktCoalesce(pktCoalesce), .pktBatchEnd(pktBatchEnd), .pktSeq(pktSeq),
    .rejValid(rejValid), .rejCode(rejCode)
  );

  int nCmp = 0, nBad = 0;
  bit done = 0;

  // behavioural reference state
  int mSt = 0, mRun = 0, mDecl = 0, mSegs = 0, mPages = 0, mSeq = 0, mBatch = 0;
  bit eP = 0, eR = 0, eCoal = 0, eBe = 0;
  int eCode = 0, eSegs = 0, ePages = 0, eSeq = 0;
  string eTag = "R11";

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  task automatic doReject(input int code, input string tag, input bit last);
    eR = 1; eCode = code; eTag = tag;
    mSt = last ? 0 : 2;
  endtask

  task automatic doAccept(input int segs, input int pages, input string tag, input bit last);
    eP = 1; eSegs = segs; ePages = pages; eSeq = mSeq; mSeq++;
    eCoal = (pages >= 4);
    eBe = last || (mBatch == 7);
    mBatch = eBe ? 0 : mBatch + 1;
    eTag = eBe ? "R10" : (eCoal ? "R7" : tag);
    mSt = 0;
  endtask

  task automatic model(input bit v, input longint a, input int l, input int c, input bit last);
    eP = 0; eR = 0;
    eTag = (mSt == 2) ? "R9" : "R11";
    if (!v) return;
    case (mSt)
      0: begin
        if (l < 64 || l > 4096) doReject(1, "R1", last);
        else if ((l % 4) != 0 || (a % 4) != 0) doReject(2, "R2", last);
        else begin
          int st, d;
          st = l / 4 - 1;
          d = c & 2047;
          if (d < st || d > st + 1024) doReject(3, "R3", last);
          else if (d == st) doAccept(1, 0, "R8", last);
          else if (last) doReject(3, "R5", last);
          else begin
            mRun = st; mDecl = d; mSegs = 1; mPages = 0; mSt = 1;
          end
        end
      end
      1: begin
        if (l == 0 || l > 4096) doReject(1, "R4", last);
        else if ((l % 4) != 0 || (a % 4) != 0) doReject(2, "R4", last);
        else begin
          mSegs++;
          mPages += ((a / 4096) != ((a + l - 1) / 4096)) ? 2 : 1;
          mRun += l / 4;
          if (mRun >= mDecl) begin
            if (mRun == mDecl) doAccept(mSegs, mPages, "R6", last);
            else doReject(3, "R5", last);
          end else if (last) doReject(3, "R5", last);
        end
      end
      default: if (last) mSt = 0;
    endcase
    if (last && !eP) mBatch = 0;
  endtask

  task automatic compare();
    logic [45:0] act, exp;
    act = {pktValid, rejValid, rejValid ? rejCode : 2'b0,
           pktValid ? {pktSegs, pktPages, pktCoalesce, pktBatchEnd, pktSeq} : 42'b0};
    exp = {eP, eR, eR ? 2'(eCode) : 2'b0,
           eP ? {12'(eSegs), 12'(ePages), eCoal, eBe, 16'(eSeq)} : 42'b0};
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", eTag, act, exp);
    end
  endtask

  task automatic step(input bit v, input longint a, input int l, input int c, input bit last);
    @(negedge clk);
    compare();
    segValid = v; segAddr = a[31:0]; segLen = l[12:0]; segCtrl = c; segLast = last;
    model(v, a, l, c, last);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    @(negedge clk);
    nCmp++;
    if (segReady !== 1'b1 || pktValid !== 1'b0 || rejValid !== 1'b0) begin
      nBad++;
      $display("FAIL R11: actual %b%b%b expected 100", segReady, pktValid, rejValid);
    end
    idle(); idle();

    // R8: header-only packet
    step(1, 'h1000, 64, 15, 1);
    idle();
    // R6: two payload segments
    step(1, 'h1000, 64, 15 + 8, 0);
    step(1, 'h2000, 16, 0, 0);
    step(1, 'h2100, 16, 0, 1);
    // R6: payload crossing a page
    step(1, 'h1000, 128, 31 + 4, 0);
    step(1, 'h2FF8, 16, 0, 1);
    // R7: two crossings -> 4 pages
    step(1, 'h1000, 64, 15 + 8, 0);
    step(1, 'h3FFC, 16, 0, 0);
    idle();
    step(1, 'h4FF8, 16, 0, 1);
    // R7 boundary: 3 pages, no coalesce
    step(1, 'h1000, 64, 15 + 8, 0);
    step(1, 'h5000, 16, 0, 0);
    step(1, 'h5FF8, 16, 0, 1);

    // R1 / R2 header checks
    step(1, 'h1000, 60, 14, 1);
    step(1, 'h1000, 4100, 1024, 1);
    step(1, 'h1000, 62, 15, 1);
    step(1, 'h1002, 68, 16, 1);
    step(1, 'h1000, 66, 16, 1);
    // R1 boundary: maximum header, zero payload
    step(1, 'h1000, 4096, 1023, 1);
    // R3 boundaries
    step(1, 'h1000, 64, 14, 1);
    step(1, 'h1000, 64, 15 + 1025, 1);
    step(1, 'h1000, 64, 15 + 1024, 0);
    step(1, 'h10000, 4096, 0, 1);
    step(1, 'h1000, 4096, 2047, 0);
    step(1, 'h20000, 4096, 0, 1);
    step(1, 'h1000, 64, 'hFFFF_F800 | 15, 1);

    // R5: overshoot, early batch end, header needing payload at batch end
    step(1, 'h1000, 64, 15 + 2, 0);
    step(1, 'h2000, 16, 0, 1);
    step(1, 'h1000, 64, 15 + 8, 0);
    step(1, 'h2000, 16, 0, 1);
    step(1, 'h1000, 64, 15 + 8, 1);

    // R4: payload checks
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2000, 0, 0, 1);
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2000, 4100, 0, 1);
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2000, 6, 0, 1);
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2002, 16, 0, 1);

    // R9: discard after reject until segLast
    step(1, 'h1000, 60, 14, 0);
    step(1, 'h1000, 64, 15, 0);
    idle();
    step(1, 'h1000, 60, 14, 0);
    step(1, 'h1000, 64, 15, 1);
    step(1, 'h1000, 64, 15, 0);
    // reject mid-payload, then discard
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2000, 0, 0, 0);
    step(1, 'h2000, 16, 0, 0);
    step(1, 'h2000, 16, 0, 1);

    // R10: nine header-only packets, then one closing the batch
    for (int i = 0; i < 9; i++) step(1, 'h1000, 64, 15, 0);
    step(1, 'h1000, 64, 15, 1);
    // 8th acceptance coinciding with segLast
    for (int i = 0; i < 7; i++) step(1, 'h1000, 64, 15, 0);
    step(1, 'h1000, 64, 15 + 4, 0);
    step(1, 'h2000, 16, 0, 1);
    step(1, 'h1000, 64, 15, 0);

    idle(); idle(); idle();
    finish_run();
  end

endmodule